// File: doc/BRIEF.md
# Three-Level IO Address Translation Walker

This block turns a 64-bit device DMA address into a physical address by walking three tables in memory. The walk starts at the region table whose origin the block receives on a configuration input. It then goes to a segment table and then to a page table. Each step reads one 64-bit entry through a simple request/grant read port and decodes the entry's validity, type and protection bits. The step then either builds the origin of the next table or ends the walk.

A requester presents an address and a write flag with a valid/ready handshake. The block then reports either the translated physical address or a fault code through a valid/ready response. Only one translation is in flight at a time. The address is cut into an 11-bit region index, an 11-bit segment index, an 8-bit page index and a 12-bit byte offset. Region and segment tables hold 2048 entries of 8 bytes each, and page tables hold 256 such entries.

Top module: `io_xlate_walker`

## Requirements
- R1: After reset, and while no request is active, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: A request with any address bit [63:42] set completes with fault code 1 and issues no memory read.
- R3: The region entry is read at root + addr[41:31]*8, the segment entry at segment origin + addr[30:20]*8, and the page entry at page-table origin + addr[19:12]*8.
- R4: A region entry with bit 5 set gives fault 2. A region entry whose bits [3:2] are not 01 gives fault 5. Otherwise the segment-table origin is the entry with bits [13:0] cleared.
- R5: A segment entry with bit 5 set gives fault 3. A segment entry whose bits [3:2] are not 00 gives fault 5. Otherwise the page-table origin is the entry with bits [10:0] cleared.
- R6: A page entry with bit 10 set gives fault 4. Otherwise the response has fault 0 and physical address (entry with bits [11:0] cleared) OR addr[11:0].
- R7: A write request that meets an entry with bit 9 set, at any level, gives fault 6. A read request is not affected by bit 9.
- R8: Within one entry, the invalid check has priority over the type check, and the type check has priority over the protection check. The walk stops at the first fault and reads no further entries.
- R9: req_ready_o stays 0 from acceptance until the response handshake completes. While rsp_valid_o is 1 and rsp_ready_i is 0, the response holds steady.
- R10: mem_req_o and mem_addr_o stay steady until mem_gnt_i. Read data is taken only when mem_rvalid_i is 1, and stalled grants do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_origin_i | input | 64 | Region table origin (8-byte aligned) |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Block idle, request can be accepted |
| req_addr_i | input | 64 | Device DMA address |
| req_write_i | input | 1 | Request is a write |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response accepted |
| rsp_paddr_o | output | 64 | Physical address (0 on fault) |
| rsp_fault_o | output | 3 | Fault code, 0 = success |
| mem_req_o | output | 1 | Entry read request |
| mem_gnt_i | input | 1 | Read request granted |
| mem_addr_o | output | 64 | Entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Entry read data |

## Verification
The assertions assume that the memory side never returns mem_rvalid_i without a granted read outstanding. They also assume that the origins, including root_origin_i, are 8-byte aligned, so every entry address is aligned. The bench memory model returns data exactly one cycle after each grant, and every table origin it uses is aligned. For R9, the responder keeps rsp_ready_i low for several cycles, which exercises the hold property. For R10, a mode that toggles the grant every cycle exercises the request-hold property.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;
  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_RANGE = 3'd1,
    FLT_RINV  = 3'd2,
    FLT_SINV  = 3'd3,
    FLT_PINV  = 3'd4,
    FLT_TYPE  = 3'd5,
    FLT_PROT  = 3'd6
  } fault_e;

  typedef enum logic [1:0] {
    LVL_REGION  = 2'd0,
    LVL_SEGMENT = 2'd1,
    LVL_PAGE    = 2'd2
  } level_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

  localparam int unsigned TBL_INV_BIT  = 5;
  localparam int unsigned PG_INV_BIT   = 10;
  localparam int unsigned PROT_BIT     = 9;
  localparam int unsigned TYPE_LSB     = 2;
  localparam logic [1:0]  TYPE_TO_SEG  = 2'b01;
  localparam logic [1:0]  TYPE_TO_PAGE = 2'b00;
endpackage

// File: rtl/io_xlate_index.sv
module io_xlate_index
  import io_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RX_W   = 11,
  parameter int unsigned SX_W   = 11,
  parameter int unsigned PX_W   = 8,
  parameter int unsigned PG_W   = 12,
  parameter int unsigned ENT_SH = 3,
  localparam int unsigned VA_W  = RX_W + SX_W + PX_W + PG_W,
  localparam int unsigned IDX_W = (RX_W > SX_W) ? RX_W : SX_W
) (
  input  logic [VA_W-1:0]   vaddr_i,
  input  level_e            level_i,
  input  logic [ADDR_W-1:0] origin_i,
  output logic [ADDR_W-1:0] ent_addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    unique case (level_i)
      LVL_REGION:  idx = IDX_W'(vaddr_i[PG_W+PX_W+SX_W +: RX_W]);
      LVL_SEGMENT: idx = IDX_W'(vaddr_i[PG_W+PX_W +: SX_W]);
      default:     idx = IDX_W'(vaddr_i[PG_W +: PX_W]);
    endcase
  end

  assign ent_addr_o = origin_i + {{(ADDR_W-IDX_W-ENT_SH){1'b0}}, idx, {ENT_SH{1'b0}}};
endmodule

// File: rtl/io_xlate_entry_check.sv
module io_xlate_entry_check
  import io_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned RT_FLAG_W = 14,
  parameter int unsigned ST_FLAG_W = 11,
  parameter int unsigned PT_FLAG_W = 12
) (
  input  logic [ADDR_W-1:0] entry_i,
  input  level_e            level_i,
  input  logic              write_i,
  output fault_e            fault_o,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] RT_MASK = ~((ADDR_W'(1) << RT_FLAG_W) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] ST_MASK = ~((ADDR_W'(1) << ST_FLAG_W) - ADDR_W'(1));
  localparam logic [ADDR_W-1:0] PT_MASK = ~((ADDR_W'(1) << PT_FLAG_W) - ADDR_W'(1));

  logic [1:0] etype;
  logic       prot_hit;

  assign etype    = entry_i[TYPE_LSB +: 2];
  assign prot_hit = write_i && entry_i[PROT_BIT];

  always_comb begin
    fault_o = FLT_NONE;
    next_o  = '0;
    unique case (level_i)
      LVL_REGION: begin
        next_o = entry_i & RT_MASK;
        if (entry_i[TBL_INV_BIT])        fault_o = FLT_RINV;
        else if (etype != TYPE_TO_SEG)   fault_o = FLT_TYPE;
        else if (prot_hit)               fault_o = FLT_PROT;
      end
      LVL_SEGMENT: begin
        next_o = entry_i & ST_MASK;
        if (entry_i[TBL_INV_BIT])        fault_o = FLT_SINV;
        else if (etype != TYPE_TO_PAGE)  fault_o = FLT_TYPE;
        else if (prot_hit)               fault_o = FLT_PROT;
      end
      default: begin
        next_o = entry_i & PT_MASK;
        if (entry_i[PG_INV_BIT])         fault_o = FLT_PINV;
        else if (prot_hit)               fault_o = FLT_PROT;
      end
    endcase
  end
endmodule

// File: rtl/io_xlate_walker.sv
module io_xlate_walker
  import io_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W    = 64,
  parameter int unsigned RX_W      = 11,
  parameter int unsigned SX_W      = 11,
  parameter int unsigned PX_W      = 8,
  parameter int unsigned PG_W      = 12,
  parameter int unsigned RT_FLAG_W = 14,
  parameter int unsigned ST_FLAG_W = 11,
  parameter int unsigned PT_FLAG_W = PG_W,
  localparam int unsigned VA_W     = RX_W + SX_W + PX_W + PG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] root_origin_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [2:0]        rsp_fault_o,
  output logic              mem_req_o,
  input  logic              mem_gnt_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  state_e            state_q;
  level_e            lvl_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              write_q;
  logic [ADDR_W-1:0] origin_q;
  logic [ADDR_W-1:0] paddr_q;
  fault_e            fault_q;

  fault_e            chk_fault;
  logic [ADDR_W-1:0] chk_next;
  logic              out_of_range;

  assign out_of_range = |req_addr_i[ADDR_W-1:VA_W];

  io_xlate_index #(
    .ADDR_W(ADDR_W), .RX_W(RX_W), .SX_W(SX_W), .PX_W(PX_W), .PG_W(PG_W), .ENT_SH(3)
  ) u_index (
    .vaddr_i   (vaddr_q),
    .level_i   (lvl_q),
    .origin_i  (origin_q),
    .ent_addr_o(mem_addr_o)
  );

  io_xlate_entry_check #(
    .ADDR_W(ADDR_W), .RT_FLAG_W(RT_FLAG_W), .ST_FLAG_W(ST_FLAG_W), .PT_FLAG_W(PT_FLAG_W)
  ) u_check (
    .entry_i(mem_rdata_i),
    .level_i(lvl_q),
    .write_i(write_q),
    .fault_o(chk_fault),
    .next_o (chk_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      lvl_q    <= LVL_REGION;
      vaddr_q  <= '0;
      write_q  <= 1'b0;
      origin_q <= '0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q  <= req_addr_i[VA_W-1:0];
          write_q  <= req_write_i;
          origin_q <= root_origin_i;
          lvl_q    <= LVL_REGION;
          paddr_q  <= '0;
          if (out_of_range) begin
            fault_q <= FLT_RANGE;
            state_q <= ST_RESP;
          end else begin
            fault_q <= FLT_NONE;
            state_q <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_gnt_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rvalid_i) begin
          if (chk_fault != FLT_NONE) begin
            fault_q <= chk_fault;
            state_q <= ST_RESP;
          end else if (lvl_q == LVL_PAGE) begin
            paddr_q <= chk_next | {{(ADDR_W-PG_W){1'b0}}, vaddr_q[PG_W-1:0]};
            state_q <= ST_RESP;
          end else begin
            origin_q <= chk_next;
            lvl_q    <= (lvl_q == LVL_REGION) ? LVL_SEGMENT : LVL_PAGE;
            state_q  <= ST_ISSUE;
          end
        end
        default: if (rsp_ready_i) state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_ISSUE);
  assign rsp_valid_o = (state_q == ST_RESP);
  assign rsp_paddr_o = paddr_q;
  assign rsp_fault_o = fault_q;
endmodule

// File: rtl/io_xlate_walker_chk.sv
module io_xlate_walker_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned VA_W   = 42
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [2:0]        rsp_fault_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_req_o && !rsp_valid_o));

  assert_range_fault_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (|req_addr_i[ADDR_W-1:VA_W]))
      |=> (rsp_valid_o && rsp_fault_o == 3'd1 && !mem_req_o));

  assert_entry_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[2:0] == 3'b000));

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_o) |-> !req_ready_o);

  assert_rsp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i)
      |=> (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  assert_mem_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

bind io_xlate_walker io_xlate_walker_chk #(.ADDR_W(ADDR_W), .VA_W(VA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_paddr_o(rsp_paddr_o),
  .rsp_fault_o(rsp_fault_o),
  .mem_req_o  (mem_req_o),
  .mem_gnt_i  (mem_gnt_i),
  .mem_addr_o (mem_addr_o)
);

// File: tb/io_xlate_walker_bench.sv
`timescale 1ns/1ps
module io_xlate_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] root_origin = 64'h10000;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [63:0] rsp_paddr;
  logic [2:0]  rsp_fault;
  logic        mem_req, mem_gnt, mem_rvalid = 1'b0;
  logic [63:0] mem_addr, mem_rdata = '0;
  logic        stall_en = 1'b0, stall_tgl = 1'b0;
  int          nrd = 0;
  logic [63:0] rd_log [4];
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  io_xlate_walker u_io_xlate_walker (
    .clk_i(clk), .rst_ni(rst_n), .root_origin_i(root_origin),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .mem_req_o(mem_req),
    .mem_gnt_i(mem_gnt), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata)
  );

  function automatic logic [63:0] mem_lookup(input logic [63:0] a);
    case (a)
      64'h10008: return 64'h20004;     // RT[1] -> ST 0x20000
      64'h10010: return 64'h20;        // RT[2] invalid
      64'h10018: return 64'h40000;     // RT[3] wrong type
      64'h10020: return 64'h40204;     // RT[4] protected
      64'h10028: return 64'h51007;     // RT[5] extra flag bits
      64'h10030: return 64'h20;        // RT[6] invalid and type 00
      64'h10038: return 64'h200;       // RT[7] type 00 and protected
      64'h20010: return 64'h30000;     // ST[2] -> PT 0x30000
      64'h20038: return 64'h20;        // ST[7] invalid
      64'h20040: return 64'h31004;     // ST[8] wrong type
      64'h30018: return 64'h55555000;  // PT[3]
      64'h30020: return 64'h66666400;  // PT[4] invalid
      64'h30028: return 64'h77777200;  // PT[5] protected
      64'h40000: return 64'h32000;
      64'h32000: return 64'hABC000;
      64'h50000: return 64'h60400;
      64'h60000: return 64'h12345800;
      default:   return 64'h0;
    endcase
  endfunction

  assign mem_gnt = stall_en ? stall_tgl : 1'b1;

  always @(posedge clk) begin
    stall_tgl  <= ~stall_tgl;
    mem_rvalid <= mem_req && mem_gnt;
    mem_rdata  <= mem_lookup(mem_addr);
    if (mem_req && mem_gnt) begin
      if (nrd < 4) rd_log[nrd] <= mem_addr;
      nrd <= nrd + 1;
    end
  end

  task automatic check(input logic ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] a, input logic wr, input int hold);
    @(negedge clk);
    nrd = 0;
    req_addr = a; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 200 && !rsp_valid; g++) @(negedge clk);
    for (int h = 0; h < hold; h++) begin
      logic [63:0] pa0;
      pa0 = rsp_paddr;
      @(negedge clk);
      check(rsp_valid && rsp_paddr == pa0 && !req_ready, "R9 response hold", {63'd0, rsp_valid}, 64'd1);
    end
  endtask

  task automatic finish_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  typedef struct packed {
    logic [63:0] addr; logic wr; logic [2:0] flt; logic [63:0] pa; logic [2:0] reads;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{64'h80203123, 1'b0, 3'd0, 64'h55555123, 3'd3},  // R3 R6
    '{64'h80203123, 1'b1, 3'd0, 64'h55555123, 3'd3},  // R7 write unprotected
    '{64'h80204010, 1'b0, 3'd4, 64'h0,        3'd3},  // R6 invalid page
    '{64'h80205fff, 1'b0, 3'd0, 64'h77777fff, 3'd3},  // R7 read of protected
    '{64'h80205fff, 1'b1, 3'd6, 64'h0,        3'd3},  // R7 page protection
    '{64'h100000000, 1'b0, 3'd2, 64'h0,       3'd1},  // R4 invalid region
    '{64'h180000000, 1'b0, 3'd5, 64'h0,       3'd1},  // R4 region type
    '{64'h80700000, 1'b0, 3'd3, 64'h0,        3'd2},  // R5 invalid segment
    '{64'h80800000, 1'b0, 3'd5, 64'h0,        3'd2},  // R5 segment type
    '{64'h200000456, 1'b1, 3'd6, 64'h0,       3'd1},  // R7 region protection
    '{64'h200000456, 1'b0, 3'd0, 64'hABC456,  3'd3},  // R7 read passes
    '{64'h2800000ab, 1'b0, 3'd0, 64'h123450ab, 3'd3}, // R4 R5 R6 flag masks
    '{64'h300000000, 1'b0, 3'd2, 64'h0,       3'd1},  // R8 invalid before type
    '{64'h380000000, 1'b1, 3'd5, 64'h0,       3'd1},  // R8 type before protection
    '{64'h40000000000, 1'b0, 3'd1, 64'h0,     3'd0},  // R2 first out-of-range
    '{64'h3FFFFFFFFFF, 1'b0, 3'd5, 64'h0,     3'd1},  // R2 last in-range
    '{64'h8000000000000000, 1'b0, 3'd1, 64'h0, 3'd0}  // R2 top bit
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(req_ready && !rsp_valid && !mem_req, "R1 in reset", {61'd0, req_ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_req, "R1 idle", {61'd0, req_ready, rsp_valid, mem_req}, 64'h4);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].addr, VECS[i].wr, 0);
      check(rsp_valid && rsp_fault == VECS[i].flt, $sformatf("R8 vec %0d fault", i), {61'd0, rsp_fault}, {61'd0, VECS[i].flt});
      check(rsp_paddr == VECS[i].pa, $sformatf("R6 vec %0d paddr", i), rsp_paddr, VECS[i].pa);
      check(nrd == int'(VECS[i].reads), $sformatf("R8 vec %0d reads", i), 64'(nrd), 64'(VECS[i].reads));
      check(!req_ready, $sformatf("R9 vec %0d busy", i), {63'd0, req_ready}, 64'd0);
      finish_rsp();
      check(req_ready, $sformatf("R1 vec %0d idle again", i), {63'd0, req_ready}, 64'd1);
    end

    // R3 entry read addresses in order
    issue(64'h80203123, 1'b0, 0);
    check(rd_log[0] == 64'h10008, "R3 region addr", rd_log[0], 64'h10008);
    check(rd_log[1] == 64'h20010, "R3 segment addr", rd_log[1], 64'h20010);
    check(rd_log[2] == 64'h30018, "R3 page addr", rd_log[2], 64'h30018);
    finish_rsp();

    // R9 response held with rsp_ready low
    issue(64'h80205fff, 1'b0, 3);
    check(rsp_paddr == 64'h77777fff, "R9 held value", rsp_paddr, 64'h77777fff);
    finish_rsp();

    // R10 stalled grants
    stall_en = 1'b1;
    issue(64'h2800000ab, 1'b0, 0);
    check(rsp_fault == 3'd0 && rsp_paddr == 64'h123450ab, "R10 stalled walk", rsp_paddr, 64'h123450ab);
    check(nrd == 3, "R10 stalled reads", 64'(nrd), 64'd3);
    finish_rsp();
    issue(64'h80700000, 1'b0, 0);
    check(rsp_fault == 3'd3, "R10 stalled fault", {61'd0, rsp_fault}, 64'd3);
    finish_rsp();
    stall_en = 1'b0;

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule